// File: doc/BRIEF.md
# Low-Power Mode Controller for an 8-bit Microcontroller Core

This block decides when the CPU core and its peripherals (interrupt logic, serial port, timers) receive clock, and what levels the address-latch strobe and program-store enable pins take while the core sleeps. Software requests a low-power state by writing two request bits. Bit 0 asks for a light sleep, idle, in which only the CPU stops. Bit 1 asks for a deep sleep, power-down, in which everything stops. The new state takes effect on the clock edge after the write.

The controller runs on a free-running clock and drives clock-enable outputs for separate clock gates. Idle ends on any enabled interrupt. Power-down ends only on an enabled level-sensitive external interrupt, which is brought in through a synchronizer. A hardware reset ends either state. On wake, the controller clears the request bit that caused the state as interrupt servicing begins. The core's registers and RAM keep their contents because their clock is held off and nothing is reset.

Top module: `lpm_top`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (run; 2'b01 is idle, 2'b10 is power-down), both request bits read 0, both clock enables are 1 and `pin_ovr_en` is 0.
- R2: In run, a write with `wr_data` = 2'b01 sets `idle_bit` at the sampling edge, and `mode_o` becomes idle on the following edge.
- R3: In idle, `cpu_clk_en` is 0, `per_clk_en` is 1, `pin_ovr_en` is 1, and `ale_ovr` and `psen_ovr` are both 1.
- R4: In run, a write with `wr_data` = 2'b10 leads to power-down. In power-down both clock enables are 0, `pin_ovr_en` is 1, and `ale_ovr` and `psen_ovr` are both 0.
- R5: A write with both bits set enters power-down only, and `idle_bit` stays 0. The two request bits are never 1 together.
- R6: In idle, `irq_any` high at an edge returns `mode_o` to run at that edge and clears `idle_bit`.
- R7: In power-down, `irq_any` has no effect, and the state and `pd_bit` are kept.
- R8: In power-down, `ext_lvl_irq` held high returns the block to run and clears `pd_bit` on the (SYNC_STAGES+1)-th edge after it rises, and not before.
- R9: Writes presented while in idle or power-down change neither request bit nor the state.
- R10: Asserting `rst_n` low in any state immediately gives run, clears both bits and sets both clock enables to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| wr_en | input | 1 | Write strobe for the request bits |
| wr_data | input | 2 | Bit 0 requests idle, bit 1 requests power-down |
| irq_any | input | 1 | Some enabled interrupt is pending |
| ext_lvl_irq | input | 1 | Enabled level-sensitive external interrupt, asynchronous |
| cpu_clk_en | output | 1 | Clock enable for the CPU core |
| per_clk_en | output | 1 | Clock enable for the peripherals |
| pin_ovr_en | output | 1 | Override the strobe pins with the values below |
| ale_ovr | output | 1 | Address-latch strobe level during sleep |
| psen_ovr | output | 1 | Program-store enable level during sleep |
| idle_bit | output | 1 | Idle request bit readback |
| pd_bit | output | 1 | Power-down request bit readback |
| mode_o | output | 2 | Current state: 00 run, 01 idle, 10 power-down |

## Verification
The bench builds the block with its default SYNC_STAGES of 2. With that value, the wake latency in power-down is exactly three edges, so the bench can check the edge before the wake and the edge of the wake one at a time. The bench also covers both exits from idle, the cases where an interrupt is ignored, writes made while asleep, the write with both bits set, and reset in every state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN  = 2'b00,
    LPM_IDLE = 2'b01,
    LPM_PD   = 2'b10
  } lpm_mode_t;

  // {cpu enable, peripheral enable}
  function automatic logic [1:0] clk_enables(input lpm_mode_t m);
    case (m)
      LPM_IDLE: clk_enables = 2'b01;
      LPM_PD:   clk_enables = 2'b00;
      default:  clk_enables = 2'b11;
    endcase
  endfunction

  // {override enable, ale level, psen level}
  function automatic logic [2:0] pin_levels(input lpm_mode_t m);
    case (m)
      LPM_IDLE: pin_levels = 3'b111;
      LPM_PD:   pin_levels = 3'b100;
      default:  pin_levels = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       irq_any,
  input  logic       wake_lvl,
  output lpm_mode_t  mode_q,
  output logic       idle_q,
  output logic       pd_q,
  output logic       enter_idle,
  output logic       enter_pd,
  output logic       wake_idle,
  output logic       wake_pd,
  output logic       wr_accept
);
  assign wr_accept  = wr_en && (mode_q == LPM_RUN);
  assign enter_pd   = (mode_q == LPM_RUN) && pd_q;
  assign enter_idle = (mode_q == LPM_RUN) && idle_q && !pd_q;
  assign wake_idle  = (mode_q == LPM_IDLE) && irq_any;
  assign wake_pd    = (mode_q == LPM_PD) && wake_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LPM_RUN;
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      if (wr_accept) begin
        pd_q   <= wr_data[1];
        idle_q <= wr_data[0] && !wr_data[1];
      end
      if (enter_pd)        mode_q <= LPM_PD;
      else if (enter_idle) mode_q <= LPM_IDLE;
      else if (wake_idle) begin
        mode_q <= LPM_RUN;
        idle_q <= 1'b0;
      end else if (wake_pd) begin
        mode_q <= LPM_RUN;
        pd_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpm_top.sv
module lpm_top
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  input  logic       irq_any,
  input  logic       ext_lvl_irq,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       pin_ovr_en,
  output logic       ale_ovr,
  output logic       psen_ovr,
  output logic       idle_bit,
  output logic       pd_bit,
  output logic [1:0] mode_o
);
  lpm_mode_t mode_q;
  logic wake_lvl, enter_idle, enter_pd, wake_idle, wake_pd, wr_accept;

  lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ext_lvl_irq), .q_sync(wake_lvl)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_any(irq_any), .wake_lvl(wake_lvl), .mode_q(mode_q),
    .idle_q(idle_bit), .pd_q(pd_bit), .enter_idle(enter_idle),
    .enter_pd(enter_pd), .wake_idle(wake_idle), .wake_pd(wake_pd),
    .wr_accept(wr_accept)
  );

  always_comb begin
    {cpu_clk_en, per_clk_en}        = clk_enables(mode_q);
    {pin_ovr_en, ale_ovr, psen_ovr} = pin_levels(mode_q);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       idle_bit,
  input logic       pd_bit,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       ale_ovr,
  input logic       psen_ovr,
  input logic       irq_any,
  input logic       wake_lvl,
  input logic       wr_en
);
  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && idle_bit && !pd_bit) |=> (mode == 2'b01));

  assert_idle_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!cpu_clk_en && per_clk_en && ale_ovr && psen_ovr));

  assert_pd_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!cpu_clk_en && !per_clk_en && !ale_ovr && !psen_ovr));

  assert_bits_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_bit && pd_bit));

  assert_idle_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && irq_any) |=> (mode == 2'b00 && !idle_bit));

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !wake_lvl) |=> (mode == 2'b10 && pd_bit));

  assert_pd_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && wake_lvl) |=> (mode == 2'b00 && !pd_bit));

  assert_sleep_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && wr_en && !irq_any) |=> ($stable(pd_bit) && mode == 2'b01));
endmodule

bind lpm_top lpm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_o), .idle_bit(idle_bit),
  .pd_bit(pd_bit), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .ale_ovr(ale_ovr), .psen_ovr(psen_ovr), .irq_any(irq_any),
  .wake_lvl(wake_lvl), .wr_en(wr_en)
);

// File: tb/tb_lpm_top.sv
`timescale 1ns/1ps
module tb_lpm_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic irq_any = 1'b0;
  logic ext_lvl_irq = 1'b0;
  logic cpu_clk_en, per_clk_en, pin_ovr_en, ale_ovr, psen_ovr, idle_bit, pd_bit;
  logic [1:0] mode_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpm_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_any(irq_any), .ext_lvl_irq(ext_lvl_irq), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .pin_ovr_en(pin_ovr_en), .ale_ovr(ale_ovr),
    .psen_ovr(psen_ovr), .idle_bit(idle_bit), .pd_bit(pd_bit), .mode_o(mode_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {cpu_en, per_en, ovr_en, ale, psen, idle, pd} then mode
  function automatic logic [7:0] outs();
    return {1'b0, cpu_clk_en, per_clk_en, pin_ovr_en, ale_ovr, psen_ovr, idle_bit, pd_bit};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; irq_any = 1'b0; ext_lvl_irq = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic write(input logic [1:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 2'b00;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "mode", {6'd0, mode_o}, 8'h00);
    chk("R1", "outputs", outs(), 8'b0_1100000);
  endtask

  task automatic t_idle_entry_and_irq_wake();
    do_reset();
    write(2'b01);
    chk("R2", "idle bit after write", {7'd0, idle_bit}, 8'h01);
    chk("R2", "still run one edge after write", {6'd0, mode_o}, 8'h00);
    step(1);
    chk("R2", "mode idle", {6'd0, mode_o}, 8'h01);
    chk("R3", "idle outputs", outs(), 8'b0_0111110);
    step(3);
    chk("R3", "idle held", {6'd0, mode_o}, 8'h01);
    irq_any = 1'b1;
    step(1);
    irq_any = 1'b0;
    chk("R6", "mode run after irq", {6'd0, mode_o}, 8'h00);
    chk("R6", "outputs after wake", outs(), 8'b0_1100000);
  endtask

  task automatic t_pd_entry_and_lvl_wake();
    do_reset();
    write(2'b10);
    step(1);
    chk("R4", "mode pd", {6'd0, mode_o}, 8'h02);
    chk("R4", "pd outputs", outs(), 8'b0_0010001);
    irq_any = 1'b1;
    step(4);
    irq_any = 1'b0;
    chk("R7", "irq ignored in pd", {6'd0, mode_o}, 8'h02);
    chk("R7", "pd bit kept", {7'd0, pd_bit}, 8'h01);
    ext_lvl_irq = 1'b1;
    step(2);
    chk("R8", "no wake before sync", {6'd0, mode_o}, 8'h02);
    step(1);
    chk("R8", "wake on third edge", {6'd0, mode_o}, 8'h00);
    chk("R8", "pd bit cleared", {7'd0, pd_bit}, 8'h00);
    ext_lvl_irq = 1'b0;
    step(3);
  endtask

  task automatic t_both_bits();
    do_reset();
    write(2'b11);
    chk("R5", "idle bit 0", {7'd0, idle_bit}, 8'h00);
    chk("R5", "pd bit 1", {7'd0, pd_bit}, 8'h01);
    step(1);
    chk("R5", "mode pd", {6'd0, mode_o}, 8'h02);
  endtask

  task automatic t_sleep_writes();
    do_reset();
    write(2'b01);
    step(1);
    write(2'b10);
    step(2);
    chk("R9", "idle kept after write", {6'd0, mode_o}, 8'h01);
    chk("R9", "bits unchanged in idle", outs() & 8'h03, 8'h02);
    do_reset();
    write(2'b10);
    step(1);
    write(2'b01);
    step(2);
    chk("R9", "pd kept after write", {6'd0, mode_o}, 8'h02);
    chk("R9", "bits unchanged in pd", outs() & 8'h03, 8'h01);
  endtask

  task automatic t_reset_from_sleep();
    do_reset();
    write(2'b01);
    step(1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "idle reset mode", {6'd0, mode_o}, 8'h00);
    chk("R10", "idle reset outs", outs(), 8'b0_1100000);
    do_reset();
    write(2'b10);
    step(1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "pd reset mode", {6'd0, mode_o}, 8'h00);
    chk("R10", "pd reset outs", outs(), 8'b0_1100000);
    do_reset();
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset_state();
        t_idle_entry_and_irq_wake();
        t_pd_entry_and_lvl_wake();
        t_both_bits();
        t_sleep_writes();
        t_reset_from_sleep();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule